// File: doc/BRIEF.md
# Shared Castout and Snoop-Push Queue

This block holds modified cache lines that are waiting to go out on the system bus. Two kinds of traffic use it. Castouts are dirty lines evicted from the cache. Snoop pushes are dirty lines that must be supplied in answer to a snoop. Each class has its own enqueue port with a ready signal. Both classes store their payloads in one common pool of storage slots. A free-slot bitmap tracks which slots are in use. For each class, a small index FIFO keeps the slots in the order they arrived.

The two classes leave through a single output port. Pushes are served before castouts, and within each class entries leave in arrival order. Castouts never fill the whole pool: they are limited to one slot fewer than the pool holds. This guarantees that a snoop response can always be buffered, however heavy the eviction traffic. A slot that is released by a dequeue becomes usable by an enqueue on the following cycle.

Top module: `shared_wb_queue`

## Requirements
- R1: After reset, `out_valid_o` is 0 and both `co_ready_o` and `pu_ready_o` are 1.
- R2: `pu_ready_o` is 1 whenever fewer than DEPTH (10) entries are held in total. When all 10 slots are in use it is 0.
- R3: Castouts may hold at most CO_MAX = DEPTH-1 (9) slots. When 9 castouts are held, `co_ready_o` is 0 even though a slot is free.
- R4: When exactly one slot is free and both classes present valid data in the same cycle, the push is accepted and `co_ready_o` is 0.
- R5: Within each class, entries leave in the order they were accepted, with their data unchanged.
- R6: While any push is held, the output presents the oldest push, with `out_is_push_o` = 1. Castouts are presented, with `out_is_push_o` = 0, only when no push is held.
- R7: A slot released by a dequeue cannot be used by an enqueue in that same cycle. It can be used from the next cycle on.
- R8: An enqueue and a dequeue in the same cycle both take effect, and the held count changes by the net amount.
- R9: While `out_valid_o` is 1 with a push at the head and `out_ready_i` is 0, the output data and class stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| co_valid_i | input | 1 | Castout enqueue request |
| co_data_i | input | DW | Castout payload |
| co_ready_o | output | 1 | Castout can be accepted |
| pu_valid_i | input | 1 | Push enqueue request |
| pu_data_i | input | DW | Push payload |
| pu_ready_o | output | 1 | Push can be accepted |
| out_valid_o | output | 1 | An entry is presented at the output |
| out_data_o | output | DW | Payload of the presented entry |
| out_is_push_o | output | 1 | 1 = presented entry is a push, 0 = castout |
| out_ready_i | input | 1 | Consumer takes the presented entry |

## Verification
The main sweep preloads every castout count from 0 to 9, fills the rest of the pool with pushes, and then drains it. This checks that the castout cap and the pool limit hold for each split. It also checks that pushes always leave first and that each class keeps its own order. For the counts where one slot remains, a cycle with both classes valid shows that the contested last slot goes to the push. Separate patterns stall the output with a full pool and attempt an enqueue in the same cycle as a dequeue. These separate the next-cycle reuse of a freed slot, output stability under backpressure, and the net update of the count when an enqueue and a dequeue coincide.

// File: rtl/cwq_pkg.sv
package cwq_pkg;
  localparam int unsigned NUM_CLS = 2;
  typedef enum logic {CLS_CO = 1'b0, CLS_PU = 1'b1} cls_e;
endpackage

// File: rtl/cwq_slot_alloc.sv
module cwq_slot_alloc #(
  parameter int unsigned DEPTH = 10,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_a_i,
  input  logic          take_b_i,
  input  logic          rel_i,
  input  logic [IW-1:0] rel_idx_i,
  output logic [IW-1:0] slot_a_o,
  output logic [IW-1:0] slot_b_o
);
  logic [DEPTH-1:0] free_q, mask_a, take_mask, rel_mask;
  logic found_a, found_b;

  // first and second free slot, lowest index first
  always_comb begin
    slot_a_o = '0;
    slot_b_o = '0;
    found_a  = 1'b0;
    found_b  = 1'b0;
    mask_a   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (free_q[i] && !found_a) begin
        found_a   = 1'b1;
        slot_a_o  = IW'(i);
        mask_a[i] = 1'b1;
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (free_q[i] && !mask_a[i] && !found_b) begin
        found_b  = 1'b1;
        slot_b_o = IW'(i);
      end
    end
  end

  always_comb begin
    take_mask = '0;
    rel_mask  = '0;
    if (take_a_i) take_mask[slot_a_o] = 1'b1;
    if (take_b_i) take_mask[slot_b_o] = 1'b1;
    if (rel_i)    rel_mask[rel_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= '1;
    else         free_q <= (free_q & ~take_mask) | rel_mask;
  end
endmodule

// File: rtl/cwq_order_fifo.sv
module cwq_order_fifo #(
  parameter int unsigned DEPTH = 10,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [IW-1:0] idx_i,
  input  logic          pop_i,
  output logic [IW-1:0] head_o,
  output logic [CW-1:0] cnt_o
);
  logic [IW-1:0] mem_q [DEPTH];
  logic [IW-1:0] wr_q, rd_q;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= idx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_o <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      cnt_o <= cnt_o + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o = mem_q[rd_q];
endmodule

// File: rtl/cwq_store.sv
module cwq_store #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned DW = 32,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_a_i,
  input  logic [IW-1:0] wa_a_i,
  input  logic [DW-1:0] wd_a_i,
  input  logic          we_b_i,
  input  logic [IW-1:0] wa_b_i,
  input  logic [DW-1:0] wd_b_i,
  input  logic [IW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_a_i) mem_q[wa_a_i] <= wd_a_i;
    if (we_b_i) mem_q[wa_b_i] <= wd_b_i;
  end

  assign rd_o = mem_q[ra_i];
endmodule

// File: rtl/shared_wb_queue.sv
module shared_wb_queue #(
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned CO_MAX = DEPTH - 1,
  parameter int unsigned DW     = 32,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          co_valid_i,
  input  logic [DW-1:0] co_data_i,
  output logic          co_ready_o,
  input  logic          pu_valid_i,
  input  logic [DW-1:0] pu_data_i,
  output logic          pu_ready_o,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_is_push_o,
  input  logic          out_ready_i
);
  import cwq_pkg::*;

  logic [IW-1:0] slot_a, slot_b, co_slot, head_idx;
  logic [CW-1:0] co_cnt, pu_cnt, total, free_cnt;
  logic co_fire, pu_fire, deq;
  logic          enq_v   [NUM_CLS];
  logic [IW-1:0] enq_idx [NUM_CLS];
  logic          deq_v   [NUM_CLS];
  logic [IW-1:0] head    [NUM_CLS];
  logic [CW-1:0] cnt     [NUM_CLS];

  assign co_cnt   = cnt[CLS_CO];
  assign pu_cnt   = cnt[CLS_PU];
  assign total    = co_cnt + pu_cnt;
  assign free_cnt = CW'(DEPTH) - total;

  // push owns the last free slot when both contend
  assign pu_ready_o = free_cnt != '0;
  assign co_ready_o = (co_cnt < CW'(CO_MAX)) &&
                      (free_cnt > (pu_valid_i ? CW'(1) : CW'(0)));
  assign pu_fire = pu_valid_i && pu_ready_o;
  assign co_fire = co_valid_i && co_ready_o;
  assign co_slot = pu_fire ? slot_b : slot_a;

  assign out_valid_o   = total != '0;
  assign out_is_push_o = pu_cnt != '0;
  assign head_idx      = out_is_push_o ? head[CLS_PU] : head[CLS_CO];
  assign deq           = out_valid_o && out_ready_i;

  assign enq_v[CLS_PU]   = pu_fire;
  assign enq_idx[CLS_PU] = slot_a;
  assign deq_v[CLS_PU]   = deq && out_is_push_o;
  assign enq_v[CLS_CO]   = co_fire;
  assign enq_idx[CLS_CO] = co_slot;
  assign deq_v[CLS_CO]   = deq && !out_is_push_o;

  cwq_slot_alloc #(.DEPTH(DEPTH)) u_alloc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_a_i  (pu_fire || co_fire),
    .take_b_i  (pu_fire && co_fire),
    .rel_i     (deq),
    .rel_idx_i (head_idx),
    .slot_a_o  (slot_a),
    .slot_b_o  (slot_b)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    cwq_order_fifo #(.DEPTH(DEPTH)) u_ord (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (enq_v[c]),
      .idx_i  (enq_idx[c]),
      .pop_i  (deq_v[c]),
      .head_o (head[c]),
      .cnt_o  (cnt[c])
    );
  end

  cwq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i  (clk_i),
    .we_a_i (pu_fire),
    .wa_a_i (slot_a),
    .wd_a_i (pu_data_i),
    .we_b_i (co_fire),
    .wa_b_i (co_slot),
    .wd_b_i (co_data_i),
    .ra_i   (head_idx),
    .rd_o   (out_data_o)
  );
endmodule

// File: rtl/cwq_chk.sv
module cwq_chk #(
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned CO_MAX = DEPTH - 1,
  parameter int unsigned DW     = 32,
  parameter int unsigned CW     = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          co_valid_i,
  input logic          co_ready_o,
  input logic          pu_valid_i,
  input logic          pu_ready_o,
  input logic          out_valid_o,
  input logic [DW-1:0] out_data_o,
  input logic          out_is_push_o,
  input logic          out_ready_i,
  input logic [CW-1:0] co_cnt,
  input logic [CW-1:0] pu_cnt
);
  // R3
  co_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    co_cnt <= CW'(CO_MAX));
  // R3
  co_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (co_cnt == CW'(CO_MAX)) |-> !co_ready_o);
  // R2
  pu_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((co_cnt + pu_cnt) < CW'(DEPTH)) |-> pu_ready_o);
  // R4
  last_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (co_valid_i && pu_valid_i && (co_cnt + pu_cnt) == CW'(DEPTH - 1)) |-> !co_ready_o);
  // R6
  push_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_cnt != '0) |-> (out_valid_o && out_is_push_o));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_is_push_o && !out_ready_i) |=>
      (out_valid_o && out_is_push_o && $stable(out_data_o)));
  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (co_cnt + pu_cnt) <= CW'(DEPTH));
endmodule

bind shared_wb_queue cwq_chk #(.DEPTH(DEPTH), .CO_MAX(CO_MAX), .DW(DW), .CW(CW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .co_valid_i    (co_valid_i),
  .co_ready_o    (co_ready_o),
  .pu_valid_i    (pu_valid_i),
  .pu_ready_o    (pu_ready_o),
  .out_valid_o   (out_valid_o),
  .out_data_o    (out_data_o),
  .out_is_push_o (out_is_push_o),
  .out_ready_i   (out_ready_i),
  .co_cnt        (co_cnt),
  .pu_cnt        (pu_cnt)
);

// File: tb/shared_wb_queue_test.sv
`timescale 1ns/1ps
module shared_wb_queue_test;
  localparam int DEPTH = 10;
  localparam int DW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic co_valid_i = 1'b0, pu_valid_i = 1'b0, out_ready_i = 1'b0;
  logic [DW-1:0] co_data_i = '0, pu_data_i = '0;
  logic co_ready_o, pu_ready_o, out_valid_o, out_is_push_o;
  logic [DW-1:0] out_data_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  shared_wb_queue #(.DEPTH(DEPTH), .DW(DW)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #2;
  endtask

  task automatic pop_expect(input logic [31:0] d, input bit is_pu, input string req);
    out_ready_i = 1'b1;
    #1;
    chk(out_valid_o == 1'b1, req, 32'(out_valid_o), 1);
    chk(out_is_push_o == is_pu, req, 32'(out_is_push_o), 32'(is_pu));
    chk(out_data_o == d, req, out_data_o, d);
    cyc();
    out_ready_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk(out_valid_o == 1'b0, "R1 out_valid", 32'(out_valid_o), 0);
    chk(co_ready_o == 1'b1, "R1 co_ready", 32'(co_ready_o), 1);
    chk(pu_ready_o == 1'b1, "R1 pu_ready", 32'(pu_ready_o), 1);
    cyc();

    // sweep castout preload 0..9, fill rest with pushes, drain
    for (int n = 0; n <= DEPTH - 1; n++) begin
      for (int i = 0; i < n; i++) begin
        co_valid_i = 1'b1; co_data_i = 32'h100 + i;
        #1 chk(co_ready_o == 1'b1, "R3 below cap", 32'(co_ready_o), 1);
        cyc();
      end
      co_valid_i = 1'b0;
      #1;
      chk(co_ready_o == (n < DEPTH - 1), "R3 cap", 32'(co_ready_o), 32'(n < DEPTH - 1));
      for (int j = 0; j < DEPTH - n - 1; j++) begin
        pu_valid_i = 1'b1; pu_data_i = 32'h200 + j;
        #1 chk(pu_ready_o == 1'b1, "R2 push room", 32'(pu_ready_o), 1);
        cyc();
      end
      pu_valid_i = 1'b1; pu_data_i = 32'h200 + (DEPTH - n - 1);
      if (n < DEPTH - 1) begin
        co_valid_i = 1'b1; co_data_i = 32'h1FF;
        #1;
        chk(pu_ready_o == 1'b1, "R4 push wins", 32'(pu_ready_o), 1);
        chk(co_ready_o == 1'b0, "R4 castout held", 32'(co_ready_o), 0);
      end else begin
        #1 chk(pu_ready_o == 1'b1, "R2 reserved slot", 32'(pu_ready_o), 1);
      end
      cyc();
      pu_valid_i = 1'b0; co_valid_i = 1'b0;
      #1 chk(pu_ready_o == 1'b0, "R2 full", 32'(pu_ready_o), 0);
      for (int j = 0; j < DEPTH - n; j++) pop_expect(32'h200 + j, 1'b1, "R6 R5 push order");
      for (int i = 0; i < n; i++) pop_expect(32'h100 + i, 1'b0, "R5 castout order");
      #1 chk(out_valid_o == 1'b0, "R5 drained", 32'(out_valid_o), 0);
    end

    // backpressure and freed-slot timing
    for (int i = 0; i < DEPTH - 1; i++) begin
      co_valid_i = 1'b1; co_data_i = 32'h300 + i; cyc();
    end
    co_valid_i = 1'b0;
    pu_valid_i = 1'b1; pu_data_i = 32'h2AA; cyc();
    pu_valid_i = 1'b0;
    cyc();
    #1;
    chk(out_data_o == 32'h2AA, "R9 hold data", out_data_o, 32'h2AA);
    chk(out_is_push_o == 1'b1, "R9 hold class", 32'(out_is_push_o), 1);
    out_ready_i = 1'b1; pu_valid_i = 1'b1; pu_data_i = 32'h2BB;
    #1 chk(pu_ready_o == 1'b0, "R7 same-cycle reuse", 32'(pu_ready_o), 0);
    cyc();
    out_ready_i = 1'b0;
    #1;
    chk(pu_ready_o == 1'b1, "R7 next-cycle reuse", 32'(pu_ready_o), 1);
    chk(co_ready_o == 1'b0, "R3 cap with free slot", 32'(co_ready_o), 0);
    cyc();
    pu_valid_i = 1'b0;
    pop_expect(32'h2BB, 1'b1, "R7 reused slot data");
    for (int i = 0; i < DEPTH - 1; i++) pop_expect(32'h300 + i, 1'b0, "R5 castout order");

    // simultaneous enqueue and dequeue
    for (int i = 1; i <= 3; i++) begin
      co_valid_i = 1'b1; co_data_i = 32'(i); cyc();
    end
    co_data_i = 32'd4; out_ready_i = 1'b1;
    #1 chk(out_data_o == 32'd1, "R8 dequeue", out_data_o, 1);
    cyc();
    co_valid_i = 1'b0; out_ready_i = 1'b0;
    for (int i = 2; i <= 4; i++) pop_expect(32'(i), 1'b0, "R8 net count");
    #1 chk(out_valid_o == 1'b0, "R8 empty after net", 32'(out_valid_o), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule